// File: doc/BRIEF.md
# Shadow ROM Remap Controller

This block steers CPU accesses that fall in two 512 KB system ROM windows. An access goes either to the physical ROM or to a 1 MB shadow RAM that is kept apart from general memory. It decodes the upper address bits, the read and write strobes and a single remap enable bit. From these it drives a ROM select, a RAM select and a RAM write enable. The memory controller and the bus handshake sit outside the block and act on these three signals.

Software fills the shadow RAM while remap is off. Those writes are blind: they land in the shadow RAM, but reads from the same windows still come from the physical ROM. Software then sets the remap enable. From that point reads are served from the shadow RAM and all writes to the windows are dropped, so the copy behaves like ROM. The enable is cleared only by the power-on reset. A machine (bus) reset leaves it as it was, so a patched image survives a warm restart.

Top module: `shadow_rom_remap`

## Requirements
- R1: An address is inside a window when addr[23:19] equals 5'b11100 (0xE00000–0xE7FFFF) or 5'b11111 (0xF80000–0xFFFFFF). Neighbouring addresses such as 0xDFFFFF, 0xE80000 and 0xF7FFFF are outside.
- R2: An access outside both windows asserts none of rom_sel, ram_sel and ram_we.
- R3: With remap off, a read inside a window asserts rom_sel only.
- R4: With remap off, a write inside a window asserts ram_sel and ram_we and not rom_sel. When rd and wr are both high, the access is treated as a write.
- R5: With remap on, a read inside a window asserts ram_sel only. rom_sel and ram_we stay low.
- R6: With remap on, a write inside a window asserts none of the three outputs.
- R7: While por_n is low, the remap enable is cleared at once, without waiting for a clock edge. After power-up, remap is off.
- R8: A low bus_rst_n leaves the remap enable unchanged and ignores ctl_wr. While bus_rst_n is low, all three outputs are low.
- R9: When ctl_wr is high at a rising clock edge, ctl_remap is loaded into the remap enable. Decoding follows the new value from that edge on.
- R10: Inside a window, with both rd and wr low, all outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_rst_n | input | 1 | Machine reset, active low |
| addr | input | 24 | CPU address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_remap | input | 1 | Remap enable value to load |
| rom_sel | output | 1 | Route the access to the physical ROM |
| ram_sel | output | 1 | Route the access to the shadow RAM |
| ram_we | output | 1 | Write enable for the shadow RAM |

## Verification
The three select outputs are combinational in address, strobes and bus reset. They are due in the same cycle as the stimulus. The bench drives each vector on the falling edge and samples two nanoseconds later, well before the next rising edge. The remap enable is the only register. A control write takes effect at the rising edge that sees ctl_wr, so the bench updates its model on that edge and checks only on the following falling edge. A power-on pulse clears the enable without a clock, and the bench checks it while no edge has passed.

// File: rtl/shadow_rom_remap.sv
module shadow_rom_remap #(
  parameter int          AW    = 24,
  parameter int          TAGW  = 5,
  parameter logic [4:0]  WIN_A = 5'b11100,
  parameter logic [4:0]  WIN_B = 5'b11111
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          bus_rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic          ctl_wr,
  input  logic          ctl_remap,
  output logic          rom_sel,
  output logic          ram_sel,
  output logic          ram_we
);
  localparam int TLSB = AW - TAGW;

  logic            remap_en;
  logic [TAGW-1:0] tag;
  logic            hit, go, wr_acc, rd_acc;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                   remap_en <= 1'b0;
    else if (bus_rst_n && ctl_wr) remap_en <= ctl_remap;

  assign tag    = addr[AW-1:TLSB];
  assign hit    = (tag == WIN_A) || (tag == WIN_B);
  assign go     = bus_rst_n && hit;
  assign wr_acc = go && wr;
  assign rd_acc = go && rd && !wr;

  assign rom_sel = rd_acc && !remap_en;
  assign ram_we  = wr_acc && !remap_en;
  assign ram_sel = ram_we || (rd_acc && remap_en);
endmodule

module shadow_rom_remap_chk (
  input logic        clk,
  input logic        por_n,
  input logic        bus_rst_n,
  input logic [23:0] addr,
  input logic        ctl_wr,
  input logic        ctl_remap,
  input logic        remap_en,
  input logic        rom_sel,
  input logic        ram_sel,
  input logic        ram_we
);
  p_outside_quiet_r2: assert property (@(posedge clk) disable iff (!por_n)
    !(addr[23:19] == 5'b11100 || addr[23:19] == 5'b11111) |-> !(rom_sel || ram_sel || ram_we));

  p_rom_only_when_off_r3: assert property (@(posedge clk) disable iff (!por_n)
    rom_sel |-> (!remap_en && !ram_sel));

  p_we_needs_sel_r4: assert property (@(posedge clk) disable iff (!por_n)
    ram_we |-> (ram_sel && !rom_sel));

  p_locked_no_write_r6: assert property (@(posedge clk) disable iff (!por_n)
    remap_en |-> !ram_we);

  p_hold_in_bus_rst_r8: assert property (@(posedge clk) disable iff (!por_n)
    !bus_rst_n |=> remap_en == $past(remap_en));

  p_quiet_in_bus_rst_r8: assert property (@(posedge clk) disable iff (!por_n)
    !bus_rst_n |-> $countones({rom_sel, ram_sel, ram_we}) == 0);

  p_load_r9: assert property (@(posedge clk) disable iff (!por_n)
    (bus_rst_n && ctl_wr) |=> remap_en == $past(ctl_remap));
endmodule

bind shadow_rom_remap shadow_rom_remap_chk u_chk (
  .clk(clk), .por_n(por_n), .bus_rst_n(bus_rst_n), .addr(addr),
  .ctl_wr(ctl_wr), .ctl_remap(ctl_remap), .remap_en(remap_en),
  .rom_sel(rom_sel), .ram_sel(ram_sel), .ram_we(ram_we)
);

// File: tb/shadow_rom_remap_bench.sv
module shadow_rom_remap_bench;
  logic clk = 1'b0;
  logic por_n = 1'b0, bus_rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic rd = 1'b0, wr = 1'b0, ctl_wr = 1'b0, ctl_remap = 1'b0;
  logic rom_sel, ram_sel, ram_we;
  logic m_en = 1'b0;
  int vectors = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shadow_rom_remap u_shadow_rom_remap (
    .clk(clk), .por_n(por_n), .bus_rst_n(bus_rst_n), .addr(addr),
    .rd(rd), .wr(wr), .ctl_wr(ctl_wr), .ctl_remap(ctl_remap),
    .rom_sel(rom_sel), .ram_sel(ram_sel), .ram_we(ram_we)
  );

  always @(posedge clk or negedge por_n)
    if (!por_n) m_en <= 1'b0;
    else if (bus_rst_n && ctl_wr) m_en <= ctl_remap;

  function automatic logic in_win(logic [23:0] a);
    return a[23:19] == 5'b11100 || a[23:19] == 5'b11111;
  endfunction

  function automatic logic [2:0] expect_out(logic [23:0] a, logic r, logic w, logic en, logic act);
    if (!act || !in_win(a)) return 3'b000;
    if (w) return en ? 3'b000 : 3'b011;
    if (r) return en ? 3'b010 : 3'b100;
    return 3'b000;
  endfunction

  function automatic string req_of(logic [23:0] a, logic r, logic w, logic en, logic act);
    if (!act) return "R8";
    if (!in_win(a)) return "R2";
    if (w) return en ? "R6" : "R4";
    if (r) return en ? "R5" : "R3";
    return "R10";
  endfunction

  task automatic chk(string req);
    logic [2:0] got, exp;
    got = {rom_sel, ram_sel, ram_we};
    exp = expect_out(addr, rd, wr, m_en, bus_rst_n);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%h rd=%b wr=%b got %b exp %b", req, addr, rd, wr, got, exp);
    end
  endtask

  task automatic access(logic [23:0] a, logic r, logic w, string req);
    @(negedge clk);
    addr = a; rd = r; wr = w;
    #2 chk(req);
  endtask

  task automatic set_remap(logic v);
    @(negedge clk);
    rd = 0; wr = 0; ctl_wr = 1; ctl_remap = v;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
  end

  initial begin
    process p;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #2 chk("R8");
    por_n = 1;
    @(negedge clk); bus_rst_n = 1;
    access(24'hE00000, 1, 0, "R7");
    access(24'hDFFFFF, 1, 0, "R1");
    access(24'hE7FFFF, 1, 0, "R1");
    access(24'hE80000, 1, 0, "R1");
    access(24'hF7FFFF, 0, 1, "R1");
    access(24'hF80000, 0, 1, "R4");
    access(24'hFFFFFF, 1, 1, "R4");
    access(24'hE12345, 0, 0, "R10");
    set_remap(1);
    access(24'hE40000, 1, 0, "R9");
    access(24'hFC0000, 0, 1, "R6");
    access(24'h123456, 1, 0, "R2");
    @(negedge clk); bus_rst_n = 0; ctl_wr = 1; ctl_remap = 0;
    access(24'hE00000, 1, 0, "R8");
    @(negedge clk); ctl_wr = 0; bus_rst_n = 1;
    access(24'hE00000, 1, 0, "R8");
    @(negedge clk); rd = 0; por_n = 0;
    addr = 24'hF80000; rd = 1;
    #1 chk("R7");
    por_n = 1;
    access(24'hF80000, 1, 0, "R7");
    for (int i = 0; i < 4000 && !done; i++) begin
      logic [23:0] a;
      int k;
      k = $urandom_range(0, 15);
      if (k == 0) set_remap(1'($urandom));
      else if (k == 1) begin
        @(negedge clk); bus_rst_n = ~bus_rst_n;
      end
      a = 24'($urandom);
      if ($urandom_range(0, 3) != 0) a[23:19] = $urandom_range(0, 1) ? 5'b11100 : 5'b11111;
      access(a, 1'($urandom), 1'($urandom), req_of(a, rd, wr, m_en, bus_rst_n));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule